// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a byte-wide, address-mapped register bank for 48 general-purpose lines, arranged as six 8-bit ports. Line k belongs to port k/8 at bit k%8. Each port has an output latch that drives its lines in open-drain style, and a port read returns the live pin levels. Writing 0 to a latch bit releases that line so it can be used as an input.

The first three ports can raise interrupts. Each line in these ports has an enable bit and a polarity bit. A pin change first passes through a two-flop synchroniser. If the line is enabled and the change is in the selected direction, an event is latched for that line. A per-port pending summary and one level interrupt output show whether any events are latched. The enable, polarity and event registers are not mapped directly. Software reaches them through a three-byte window, and a page register chooses which set the window shows. Software clears an event by writing the line's enable bit to 0 and then back to 1.

Top module: `gpio_edge_bank`

## Requirements
- R1: Writing offset p (0 to 5) stores the byte in port p's output latch, which drives `pinDrive[8p+7:8p]`. No other latch changes.
- R2: Reading offset p (0 to 5) returns the current `pinIn[8p+7:8p]`, without delay.
- R3: Offset 7 holds a page byte that reads back as written. The page selects what offsets 8, 9 and 10 show for ports 0, 1 and 2: 0x40 gives polarity, 0x80 gives enable, and 0xC0 gives event identification. With any other page, the window reads 0 and ignores writes.
- R4: A line in ports 0 to 2 latches an event only while its enable bit is 1. With polarity 1 it latches on a rising pin change, and with polarity 0 on a falling one. A change made before a rising clock edge is latched on the third rising edge. A change in the other direction, or on a disabled line, latches nothing.
- R5: With page 0xC0, reading offset 8+n returns port n's latched events, one bit per line. Writes through that page change nothing.
- R6: While a line's enable bit is 0, its latched event is discarded. Writing the enable bit 0 and then 1 clears the event and re-arms the line.
- R7: Offset 6 reads the pending summary. Bit n is the OR of port n's events for n = 0 to 2, and bits 7 to 3 read 0. `irqOut` is high while any summary bit is set.
- R8: Ports 3 to 5 have no interrupt logic. Their pins never affect `irqOut` or the summary.
- R9: After reset, all output latches, enables, polarity bits, events and the page byte are 0, and `irqOut` is low.
- R10: Offsets 11 to 15 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register byte offset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| pinIn | input | 48 | Sampled pin levels |
| pinDrive | output | 48 | Output latch contents |
| irqOut | output | 1 | Level interrupt, active high |

## Verification
The bench builds the block with its default parameters. These are six 8-bit ports, of which three can interrupt, and a two-stage synchroniser. With these values the window sits at offsets 8 to 10, offsets 11 to 15 are unused, and the summary has exactly three live bits. The bench can therefore test every page against every windowed offset, confirm that the unused offsets read zero, and measure the three-edge latency from a pin change to the interrupt. It also checks that toggling the upper three ports never reaches the summary.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 6;
  localparam int IRQ_PORTS = 3;
  localparam int ADDR_W    = 4;
  localparam int IDX_W     = $clog2(NUM_PORTS);

  localparam logic [PORT_W-1:0] PAGE_POL = 8'h40;
  localparam logic [PORT_W-1:0] PAGE_EN  = 8'h80;
  localparam logic [PORT_W-1:0] PAGE_ID  = 8'hC0;

  typedef enum logic [2:0] {
    RD_PIN, RD_SUM, RD_PAGE, RD_EN, RD_POL, RD_ID, RD_ZERO
  } rdSel_e;

  // Strobes and selects from the decoder to the datapath
  typedef struct packed {
    logic [NUM_PORTS-1:0] outWr;
    logic [IRQ_PORTS-1:0] enWr;
    logic [IRQ_PORTS-1:0] polWr;
    rdSel_e               rdSel;
    logic [IDX_W-1:0]     rdIdx;
    logic [PORT_W-1:0]    pageVal;
  } strobe_t;
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NP = NUM_PORTS,
  parameter int DW = PORT_W,
  parameter int NI = IRQ_PORTS,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWr,
  input  logic [DW-1:0] busWdata,
  output strobe_t       strb
);
  localparam logic [AW-1:0] A_SUM  = AW'(NP);
  localparam logic [AW-1:0] A_PAGE = AW'(NP + 1);
  localparam logic [AW-1:0] A_WIN  = AW'(NP + 2);
  localparam logic [AW-1:0] A_HOLE = AW'(NP + 2 + NI);

  logic [DW-1:0] pageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          pageQ <= '0;
    else if (busWr && busAddr == A_PAGE) pageQ <= busWdata;
  end

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_ZERO;
    strb.pageVal = pageQ;
    if (busAddr < A_SUM) begin
      strb.rdSel = RD_PIN;
      strb.rdIdx = IDX_W'(busAddr);
      for (int k = 0; k < NP; k++)
        strb.outWr[k] = busWr && (busAddr == AW'(k));
    end else if (busAddr == A_SUM) begin
      strb.rdSel = RD_SUM;
    end else if (busAddr == A_PAGE) begin
      strb.rdSel = RD_PAGE;
    end else if (busAddr >= A_WIN && busAddr < A_HOLE) begin
      strb.rdIdx = IDX_W'(busAddr - A_WIN);
      case (pageQ)
        PAGE_EN: begin
          strb.rdSel = RD_EN;
          for (int k = 0; k < NI; k++)
            strb.enWr[k] = busWr && (busAddr == AW'(NP + 2 + k));
        end
        PAGE_POL: begin
          strb.rdSel = RD_POL;
          for (int k = 0; k < NI; k++)
            strb.polWr[k] = busWr && (busAddr == AW'(NP + 2 + k));
        end
        PAGE_ID: strb.rdSel = RD_ID;   // read only, writes dropped
        default: strb.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_irqport.sv
module gpio_edge_irqport #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enWr,
  input  logic          polWr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pinIn,
  output logic [DW-1:0] enQ,
  output logic [DW-1:0] polQ,
  output logic [DW-1:0] evQ
);
  logic [DW-1:0] syncQ [SYNC];
  logic [DW-1:0] prevQ;
  logic [DW-1:0] rise, fall, hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC-1];
    end
  end

  assign rise = syncQ[SYNC-1] & ~prevQ;
  assign fall = ~syncQ[SYNC-1] & prevQ;
  assign hit  = enQ & ((polQ & rise) | (~polQ & fall));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= '0;
      polQ <= '0;
      evQ  <= '0;
    end else begin
      if (enWr)  enQ  <= wdata;
      if (polWr) polQ <= wdata;
      // a disabled line holds no event
      evQ <= (evQ | hit) & enQ;
    end
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NP   = NUM_PORTS,
  parameter int DW   = PORT_W,
  parameter int NI   = IRQ_PORTS,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [DW-1:0]    wdata,
  input  logic [NP*DW-1:0] pinIn,
  output logic [NP*DW-1:0] pinDrive,
  output logic [DW-1:0]    rdData,
  output logic             irqOut
);
  logic [DW-1:0] enArr  [NI];
  logic [DW-1:0] polArr [NI];
  logic [DW-1:0] evArr  [NI];
  logic [NI-1:0] sumVec;

  for (genvar p = 0; p < NP; p++) begin : g_latch
    logic [DW-1:0] latchQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              latchQ <= '0;
      else if (strb.outWr[p]) latchQ <= wdata;
    end
    assign pinDrive[p*DW +: DW] = latchQ;
  end

  for (genvar i = 0; i < NI; i++) begin : g_irq
    gpio_edge_irqport #(.DW(DW), .SYNC(SYNC)) portInst (
      .clk   (clk),
      .rstN  (rstN),
      .enWr  (strb.enWr[i]),
      .polWr (strb.polWr[i]),
      .wdata (wdata),
      .pinIn (pinIn[i*DW +: DW]),
      .enQ   (enArr[i]),
      .polQ  (polArr[i]),
      .evQ   (evArr[i])
    );
    assign sumVec[i] = |evArr[i];
  end

  assign irqOut = |sumVec;

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_PIN:
        for (int p = 0; p < NP; p++)
          if (strb.rdIdx == IDX_W'(p)) rdData = pinIn[p*DW +: DW];
      RD_SUM:  rdData = DW'(sumVec);
      RD_PAGE: rdData = strb.pageVal;
      RD_EN:
        for (int i = 0; i < NI; i++)
          if (strb.rdIdx == IDX_W'(i)) rdData = enArr[i];
      RD_POL:
        for (int i = 0; i < NI; i++)
          if (strb.rdIdx == IDX_W'(i)) rdData = polArr[i];
      RD_ID:
        for (int i = 0; i < NI; i++)
          if (strb.rdIdx == IDX_W'(i)) rdData = evArr[i];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int NP   = NUM_PORTS,
  parameter int DW   = PORT_W,
  parameter int NI   = IRQ_PORTS,
  parameter int AW   = ADDR_W,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWr,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  input  logic [NP*DW-1:0] pinIn,
  output logic [NP*DW-1:0] pinDrive,
  output logic             irqOut
);
  strobe_t strb;

  gpio_edge_ctrl #(.NP(NP), .DW(DW), .NI(NI), .AW(AW)) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .strb     (strb)
  );

  gpio_edge_dp #(.NP(NP), .DW(DW), .NI(NI), .SYNC(SYNC)) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (busWdata),
    .pinIn    (pinIn),
    .pinDrive (pinDrive),
    .rdData   (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int NP = 6,
  parameter int DW = 8,
  parameter int NI = 3,
  parameter int AW = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [AW-1:0]    busAddr,
  input logic             busWr,
  input logic [DW-1:0]    busWdata,
  input logic [DW-1:0]    busRdata,
  input logic [NP*DW-1:0] pinIn,
  input logic [NP*DW-1:0] pinDrive,
  input logic             irqOut
);
  for (genvar k = 0; k < NP; k++) begin : g_port
    // R1
    pin_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == AW'(k)) |=> pinDrive[k*DW +: DW] == $past(busWdata));
    // R2
    pin_read_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == AW'(k)) |-> busRdata == pinIn[k*DW +: DW]);
  end

  // R1
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr || busAddr >= AW'(NP)) |=> $stable(pinDrive));

  // R7
  summary_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == AW'(NP)) |-> (busRdata[DW-1:NI] == '0 && irqOut == (|busRdata[NI-1:0])));

  // R10
  hole_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= AW'(NP + 2 + NI)) |-> busRdata == '0);

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!irqOut && pinDrive == '0));
endmodule

bind gpio_edge_bank gpio_edge_chk #(.NP(NP), .DW(DW), .NI(NI), .AW(AW)) chkInst (.*);

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  busAddr = 0;
  logic        busWr = 0;
  logic [7:0]  busWdata = 0;
  logic [7:0]  busRdata;
  logic [47:0] pinIn = 0;
  logic [47:0] pinDrive;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_bank uut (.*);

  // {isWrite, addr, wdata, expected, requirement number}
  localparam int NV = 27;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'd7,  8'h80, 8'h00, 4'd3},
    {1'b1, 4'd8,  8'hA5, 8'h00, 4'd3},
    {1'b0, 4'd8,  8'h00, 8'hA5, 4'd3},
    {1'b1, 4'd7,  8'h40, 8'h00, 4'd3},
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd3},
    {1'b1, 4'd9,  8'h3C, 8'h00, 4'd3},
    {1'b0, 4'd9,  8'h00, 8'h3C, 4'd3},
    {1'b0, 4'd7,  8'h00, 8'h40, 4'd3},
    {1'b1, 4'd7,  8'hC0, 8'h00, 4'd5},
    {1'b1, 4'd8,  8'hFF, 8'h00, 4'd5},
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd5},
    {1'b1, 4'd7,  8'h80, 8'h00, 4'd5},
    {1'b0, 4'd8,  8'h00, 8'hA5, 4'd5},
    {1'b0, 4'd0,  8'h00, 8'hBC, 4'd2},
    {1'b0, 4'd5,  8'h00, 8'h12, 4'd2},
    {1'b0, 4'd6,  8'h00, 8'h00, 4'd7},
    {1'b1, 4'd7,  8'h11, 8'h00, 4'd3},
    {1'b1, 4'd8,  8'hFF, 8'h00, 4'd3},
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd3},
    {1'b1, 4'd7,  8'h80, 8'h00, 4'd3},
    {1'b0, 4'd8,  8'h00, 8'hA5, 4'd3},
    {1'b1, 4'd12, 8'h77, 8'h00, 4'd10},
    {1'b0, 4'd12, 8'h00, 8'h00, 4'd10},
    {1'b1, 4'd8,  8'h00, 8'h00, 4'd6},
    {1'b1, 4'd7,  8'h40, 8'h00, 4'd4},
    {1'b1, 4'd9,  8'h00, 8'h00, 4'd4},
    {1'b0, 4'd9,  8'h00, 8'h00, 4'd4}
  };

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWr = 0;
    #2 d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, {40'h0, d}, {40'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    pinIn = 48'h1234_5678_9ABC;
    idle(3);
    rstN = 1;
    idle(1);
    // R9 reset state
    check("R9 irq", {47'h0, irqOut}, 48'h0);
    check("R9 latches", pinDrive, 48'h0);
    rdChk("R9 page", 4'd7, 8'h00);
    rdChk("R9 summary", 4'd6, 8'h00);
    rdChk("R9 window", 4'd8, 8'h00);

    // table walk: R2 R3 R5 R7 R10
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) wr(VEC[v][23:20], VEC[v][19:12]);
      else rdChk($sformatf("R%0d vec%0d", VEC[v][3:0], v), VEC[v][23:20], VEC[v][11:4]);
    end

    // R1 output latches
    wr(4'd3, 8'h5A);
    idle(1);
    check("R1 port3", pinDrive, 48'h0000_5A00_0000);
    wr(4'd0, 8'hC3);
    idle(1);
    check("R1 port0", pinDrive, 48'h0000_5A00_00C3);

    pinIn = 48'h0;
    idle(4);

    // R4 rising edge, latency of three edges
    wr(4'd7, 8'h40); wr(4'd8, 8'h01);
    wr(4'd7, 8'h80); wr(4'd8, 8'h01);
    idle(1);
    pinIn[0] = 1'b1;
    idle(2);
    check("R4 latency before", {47'h0, irqOut}, 48'h0);
    idle(1);
    check("R4 rising", {47'h0, irqOut}, 48'h1);
    wr(4'd7, 8'hC0);
    rdChk("R5 ident port0", 4'd8, 8'h01);
    rdChk("R7 summary port0", 4'd6, 8'h01);

    // R4 falling edge on line 9
    pinIn[9] = 1'b1;
    idle(4);
    wr(4'd7, 8'h80); wr(4'd9, 8'h02);
    idle(1);
    pinIn[9] = 1'b0;
    idle(4);
    rdChk("R7 summary two ports", 4'd6, 8'h03);
    wr(4'd7, 8'hC0);
    rdChk("R5 ident port1", 4'd9, 8'h02);

    // R4 wrong direction and disabled line on port 2
    pinIn[17:16] = 2'b11;
    idle(4);
    wr(4'd7, 8'h40); wr(4'd10, 8'h01);
    wr(4'd7, 8'h80); wr(4'd10, 8'h01);
    idle(1);
    pinIn[17:16] = 2'b00;
    idle(4);
    wr(4'd7, 8'hC0);
    rdChk("R4 wrong direction/disabled", 4'd10, 8'h00);
    rdChk("R4 summary unchanged", 4'd6, 8'h03);

    // R6 acknowledge by enable 0 then 1
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd8, 8'h01);
    wr(4'd7, 8'hC0);
    rdChk("R6 ack port0 ident", 4'd8, 8'h00);
    rdChk("R6 ack port0 summary", 4'd6, 8'h02);
    check("R6 irq still high", {47'h0, irqOut}, 48'h1);
    wr(4'd7, 8'h80); wr(4'd9, 8'h00); wr(4'd9, 8'h02);
    idle(1);
    rdChk("R6 ack port1 summary", 4'd6, 8'h00);
    check("R6 irq low", {47'h0, irqOut}, 48'h0);

    // R6 re-armed line fires again, then disable discards it
    pinIn[0] = 1'b0;
    idle(4);
    check("R6 fall ignored", {47'h0, irqOut}, 48'h0);
    pinIn[0] = 1'b1;
    idle(4);
    check("R6 re-armed", {47'h0, irqOut}, 48'h1);
    wr(4'd8, 8'h00);
    idle(2);
    check("R6 discard", {47'h0, irqOut}, 48'h0);

    // R8 upper ports never interrupt
    wr(4'd11, 8'hFF);
    rdChk("R8 no enable for port3", 4'd11, 8'h00);
    pinIn[47:24] = 24'hFFFFFF;
    idle(4);
    pinIn[47:24] = 24'h000000;
    idle(4);
    check("R8 irq", {47'h0, irqOut}, 48'h0);
    rdChk("R8 summary", 4'd6, 8'h00);

    summary();
  end
endmodule